// File: doc/BRIEF.md
# Serial Control Port for a Three-Source Audio/Video Switch

This block is the control side of a three-source audio/video switch. It is a target-only I2C port that runs from a fast system clock and oversamples the bus clock and data lines. It filters out short glitches and detects start and stop conditions. It answers to one of two 7-bit addresses, and a static select pin chooses which one.

A write carries no register pointer. The data bytes after the address land in the four 8-bit control registers in a fixed sequence, always starting at register 0. A read returns one fixed identification byte. A general-call write with the reset code puts every register back to its default value. The four registers leave the block as parallel buses that drive the switch fabric and gain settings. The block drives the data line only through a pull-low enable, for an open-drain pad.

Top module: `avsw_ctl_port`

## Requirements
- R1: While `rst` is high and after it, all four control outputs hold their default values (0x00 each by default) and `sda_pull` is low.
- R2: With `addr_sel` high the port acknowledges address 7'h48. With `addr_sel` low it acknowledges 7'h50. It also acknowledges the general-call write byte 0x00. It acknowledges no other address byte and does not pull SDA again until the next start.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop releases SDA. A repeated start begins a new transfer from register 0.
- R4: In a write, the first data byte goes to register 0, the second to register 1, the third to register 2 and the fourth to register 3. Each byte is acknowledged by pulling SDA low during the ninth SCL pulse.
- R5: Data bytes after the fourth are acknowledged and discarded.
- R6: A register changes only at the falling SCL edge that ends the acknowledge of its own byte. The registers that follow it keep their values until their own bytes arrive.
- R7: Register 3 is written only when register 2 was written earlier in the same transfer. A three-byte write leaves register 3 unchanged.
- R8: A read addressed to the port returns 0x20, MSB first, with the bits changing while SCL is low. After the master's acknowledge bit the port releases SDA.
- R9: A general-call write followed by data byte 0x06 restores all defaults. Any other general-call data byte leaves the registers unchanged.
- R10: A change on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks (4 by default, 80 ns at 50 MHz) has no effect on the bus state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 MHz |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| addr_sel | input | 1 | 1 selects address 7'h48, 0 selects 7'h50 |
| sda_pull | output | 1 | 1 pulls the data pad low |
| ctl0 | output | 8 | Control register 0 |
| ctl1 | output | 8 | Control register 1 |
| ctl2 | output | 8 | Control register 2 |
| ctl3 | output | 8 | Control register 3 |

## Verification
The hardest case to reach from the pins is a bus glitch that arrives in the middle of a bit. The stimulus injects an SCL dropout and an SDA flip while SCL is high, both shorter than the filter window, inside a live address byte. An unfiltered design would count an extra bit or see a false start or stop, and it would then fail to acknowledge. The other hard cases depend on how far a transfer has progressed: the register-3 gate and the discard of extra bytes only show up after a set number of bytes. A full sweep of all 128 address bytes under both select settings covers the address decode.

// File: rtl/avsw_ctl_pkg.sv
package avsw_ctl_pkg;
  localparam int NREGS = 4;
  localparam int RW    = 8;
  localparam logic [7:0] ID_BYTE  = 8'h20;
  localparam logic [7:0] GC_RESET = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WDATA,
    ST_ACK_D,
    ST_RDATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/avsw_line_filter.sv
module avsw_line_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic filt_o
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(FILT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CMAX) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(sync_q[1]) == filt_q)); // R10
endmodule

// File: rtl/avsw_bus_engine.sv
module avsw_bus_engine
  import avsw_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [6:0] own_addr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [1:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       gc_rst,
  output logic       txn_start
);
  localparam int IDXW = $clog2(NREGS + 1);

  bus_state_e      state_q;
  logic            scl_d, sda_d;
  logic [3:0]      bit_cnt_q;
  logic [7:0]      sr_q;
  logic [7:0]      tx_q;
  logic            rd_q, gc_q;
  logic [IDXW-1:0] idx_q;
  logic            oe_q, wr_en_q, gc_rst_q, start_q;
  logic [1:0]      wr_idx_q;
  logic [7:0]      wr_data_q;

  logic start_ev, stop_ev, rise_ev, fall_ev;
  assign start_ev = scl_f && scl_d && sda_d && !sda_f;
  assign stop_ev  = scl_f && scl_d && !sda_d && sda_f;
  assign rise_ev  = scl_f && !scl_d;
  assign fall_ev  = !scl_f && scl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    wr_en_q  <= 1'b0;
    gc_rst_q <= 1'b0;
    start_q  <= 1'b0;
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      tx_q      <= '0;
      rd_q      <= 1'b0;
      gc_q      <= 1'b0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else if (start_ev) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      gc_q      <= 1'b0;
      idx_q     <= '0;
      start_q   <= 1'b1;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (rise_ev && bit_cnt_q < 4'd8) begin
            sr_q      <= {sr_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (fall_ev && bit_cnt_q == 4'd8) begin
            if (state_q == ST_WDATA) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK_D;
            end else if (sr_q[7:1] == own_addr) begin
              oe_q    <= 1'b1;
              rd_q    <= sr_q[0];
              state_q <= ST_ACK_A;
            end else if (sr_q == 8'h00) begin
              oe_q    <= 1'b1;
              rd_q    <= 1'b0;
              gc_q    <= 1'b1;
              state_q <= ST_ACK_A;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ACK_A: begin
          if (fall_ev) begin
            bit_cnt_q <= '0;
            if (rd_q) begin
              oe_q    <= ~ID_BYTE[7];
              tx_q    <= {ID_BYTE[6:0], 1'b0};
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WDATA;
            end
          end
        end
        ST_ACK_D: begin
          if (fall_ev) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WDATA;
            if (gc_q) begin
              gc_rst_q <= (sr_q == GC_RESET);
            end else if (idx_q < IDXW'(NREGS)) begin
              wr_en_q   <= 1'b1;
              wr_idx_q  <= idx_q[1:0];
              wr_data_q <= sr_q;
              idx_q     <= idx_q + 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (rise_ev && bit_cnt_q < 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (fall_ev) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_SKIP;
            end else begin
              oe_q <= ~tx_q[7];
              tx_q <= {tx_q[6:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign wr_en     = wr_en_q;
  assign wr_idx    = wr_idx_q;
  assign wr_data   = wr_data_q;
  assign gc_rst    = gc_rst_q;
  assign txn_start = start_q;

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !scl_f); // R4
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !oe_q); // R3
  AST_WRITE_AT_ACK_END: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> (!scl_f && $past(scl_d))); // R6
endmodule

// File: rtl/avsw_ctl_regs.sv
module avsw_ctl_regs
  import avsw_ctl_pkg::*;
#(
  parameter logic [NREGS*RW-1:0] DEFAULTS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txn_start,
  input  logic                wr_en,
  input  logic [1:0]          wr_idx,
  input  logic [RW-1:0]       wr_data,
  input  logic                gc_rst,
  output logic [NREGS*RW-1:0] regs_o
);
  logic r2_seen_q;

  always_ff @(posedge clk) begin
    if (rst || txn_start) r2_seen_q <= 1'b0;
    else if (wr_en && wr_idx == 2'd2) r2_seen_q <= 1'b1;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [RW-1:0] q;
    logic          allow;
    assign allow = (g != 3) || r2_seen_q;
    always_ff @(posedge clk) begin
      if (rst || gc_rst) q <= DEFAULTS[g*RW +: RW];
      else if (wr_en && wr_idx == 2'(g) && allow) q <= wr_data;
    end
    assign regs_o[g*RW +: RW] = q;
  end

  AST_R3_AFTER_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 2'd3) |-> r2_seen_q); // R7
  AST_GC_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    gc_rst |=> (regs_o == DEFAULTS)); // R9
endmodule

// File: rtl/avsw_ctl_port.sv
module avsw_ctl_port
  import avsw_ctl_pkg::*;
#(
  parameter int                  FILT_CYCLES = 4,
  parameter logic [6:0]          ADDR_OPEN   = 7'h48,
  parameter logic [6:0]          ADDR_TIED   = 7'h50,
  parameter logic [NREGS*RW-1:0] DEFAULTS    = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_pull,
  output logic [7:0] ctl0,
  output logic [7:0] ctl1,
  output logic [7:0] ctl2,
  output logic [7:0] ctl3
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    avsw_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .pin_i(raw[l]), .filt_o(filt[l]));
  end

  logic [6:0]          own_addr;
  logic                wr_en, gc_rst, txn_start;
  logic [1:0]          wr_idx;
  logic [7:0]          wr_data;
  logic [NREGS*RW-1:0] regs;

  assign own_addr = addr_sel ? ADDR_OPEN : ADDR_TIED;

  avsw_bus_engine u_eng (
    .clk(clk), .rst(rst), .scl_f(filt[0]), .sda_f(filt[1]),
    .own_addr(own_addr), .sda_oe(sda_pull), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .gc_rst(gc_rst),
    .txn_start(txn_start));

  avsw_ctl_regs #(.DEFAULTS(DEFAULTS)) u_regs (
    .clk(clk), .rst(rst), .txn_start(txn_start), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .gc_rst(gc_rst), .regs_o(regs));

  assign ctl0 = regs[7:0];
  assign ctl1 = regs[15:8];
  assign ctl2 = regs[23:16];
  assign ctl3 = regs[31:24];

  AST_RESET_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> !sda_pull); // R1
endmodule

// File: tb/avsw_ctl_port_tb.sv
module avsw_ctl_port_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic sda_pull, sda_line;
  logic [7:0] ctl0, ctl1, ctl2, ctl3;
  int checks = 0, fails = 0;
  logic [7:0] ex [4];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  avsw_ctl_port u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_pull(sda_pull),
    .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2), .ctl3(ctl3));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(ctl0 == ex[0], req, ctl0, ex[0]);
    chk(ctl1 == ex[1], req, ctl1, ex[1]);
    chk(ctl2 == ex[2], req, ctl2, ex[2]);
    chk(ctl3 == ex[3], req, ctl3, ex[3]);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    if (glitch) begin
      scl_m = 1'b0; repeat (3) @(negedge clk); scl_m = 1'b1;
      repeat (2) @(negedge clk);
      sda_m = ~b; repeat (3) @(negedge clk); sda_m = b;
    end
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = !sda_line;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      d[i] = sda_line;
      wq();
      scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [6:0] a, input int n, input logic [7:0] base,
                           input string req);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, 1'b0, ack);
    chk(ack, req, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(base + 8'(k * 17), 1'b0, ack);
      chk(ack, req, ack, 1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    for (int i = 0; i < 4; i++) ex[i] = 8'h00;
    repeat (10) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk_regs("R1 defaults");
    chk(sda_pull == 1'b0, "R1 released", sda_pull, 0);

    // R2: full address sweep under both select settings
    for (int s = 1; s >= 0; s--) begin
      addr_sel = s[0];
      for (int a = 0; a < 128; a++) begin
        bit exp_ack;
        exp_ack = (a == 0) || (s == 1 && a == 'h48) || (s == 0 && a == 'h50);
        bus_start();
        send_byte({7'(a), 1'b0}, 1'b0, ack);
        chk(ack == exp_ack, "R2 address ack", ack, exp_ack);
        chk(sda_pull == 1'b0, "R2 release after ninth clock", sda_pull, 0);
        bus_stop();
      end
    end
    chk_regs("R2 sweep leaves regs");
    addr_sel = 1'b1;

    // R4/R6: two bytes, check between them
    bus_start();
    send_byte(8'h90, 1'b0, ack);
    chk(ack, "R4 addr", ack, 1);
    send_byte(8'hA1, 1'b0, ack);
    chk(ack, "R4 data ack", ack, 1);
    chk(ctl0 == 8'hA1, "R6 reg0 after its byte", ctl0, 8'hA1);
    chk(ctl1 == 8'h00, "R6 reg1 untouched yet", ctl1, 0);
    send_byte(8'hB2, 1'b0, ack);
    chk(ack, "R4 data ack", ack, 1);
    bus_stop();
    ex[0] = 8'hA1; ex[1] = 8'hB2;
    chk_regs("R4 two-byte write");

    // R7: three bytes leave reg3 alone
    write_seq(7'h48, 3, 8'h11, "R7 three-byte acks");
    ex[0] = 8'h11; ex[1] = 8'h22; ex[2] = 8'h33;
    chk_regs("R7 reg3 unchanged");

    // R5: six bytes, extras acked and dropped
    write_seq(7'h48, 6, 8'h40, "R5 all bytes acked");
    ex[0] = 8'h40; ex[1] = 8'h51; ex[2] = 8'h62; ex[3] = 8'h73;
    chk_regs("R5 first four kept");

    // R8: read identification byte
    bus_start();
    send_byte(8'h91, 1'b0, ack);
    chk(ack, "R8 read addr ack", ack, 1);
    read_byte(1'b1, rd);
    chk(rd == 8'h20, "R8 id byte", rd, 8'h20);
    chk(sda_pull == 1'b0, "R8 released", sda_pull, 0);
    bus_stop();
    chk_regs("R8 read leaves regs");

    // R2: foreign address, following data not acked
    bus_start();
    send_byte(8'hA0, 1'b0, ack);
    chk(!ack, "R2 foreign addr", ack, 0);
    send_byte(8'h5C, 1'b0, ack);
    chk(!ack, "R2 no ack after miss", ack, 0);
    bus_stop();
    chk_regs("R2 foreign write ignored");

    // R9: general call
    bus_start();
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h04, 1'b0, ack);
    chk(ack, "R9 gc data ack", ack, 1);
    bus_stop();
    chk_regs("R9 other gc code ignored");
    bus_start();
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h06, 1'b0, ack);
    bus_stop();
    for (int i = 0; i < 4; i++) ex[i] = 8'h00;
    chk_regs("R9 gc reset");

    // R10: glitches inside every bit of the address byte
    bus_start();
    send_byte(8'h90, 1'b1, ack);
    chk(ack, "R10 glitched addr ack", ack, 1);
    send_byte(8'h5A, 1'b0, ack);
    bus_stop();
    ex[0] = 8'h5A;
    chk_regs("R10 write after glitches");

    // R3: repeated start restarts at register 0
    bus_start();
    send_byte(8'h90, 1'b0, ack);
    send_byte(8'hC3, 1'b0, ack);
    scl_m = 1'b0; sda_m = 1'b1; wq();
    bus_start();
    send_byte(8'h90, 1'b0, ack);
    chk(ack, "R3 repeated start ack", ack, 1);
    send_byte(8'hD4, 1'b0, ack);
    bus_stop();
    ex[0] = 8'hD4;
    chk_regs("R3 repeated start");
    chk(sda_pull == 1'b0, "R3 stop releases", sda_pull, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule